// File: doc/BRIEF.md
# Paged Read Sequencer with Page Redirection

This block is the byte-level sequencer behind the three read commands of an add-only memory. The memory has a data field of 256 pages of 32 bytes and a separate status field. The link layer hands the block the bytes it receives and a reset indication. The block answers with one transmit byte at a time, and moves to the next byte when the link asks for it. The memory contents come in through a combinational read port. The block drives the address and a field select, and it takes the byte back in the same cycle.

There are three commands. A plain read streams the data field. A status read closes every 8-byte status page with a CRC. An extended read walks the data field page by page. For each page it first sends that page's redirection byte with a CRC, then the page data with a CRC. All three commands use the same CRC-16 engine, but each one clears and seeds it at different points. Once a command runs past its last item, the block sends all ones until the link resets it.

Top module: `paged_read_seq`

## Requirements
- R1: In idle, only the received bytes F0H (plain read), AAH (status read) and A5H (extended read) start a command. Any other byte is ignored. While idle or while taking in the address, tx_byte is FFH.
- R2: After the command come two received bytes: the address low byte, then the high byte. Only the low 13 address bits are kept. The CRC still covers both bytes exactly as they were received.
- R3: A plain read returns data bytes from the start address up to and including 1FFFH. It then sends the CRC over the command, both address bytes and every data byte, and after that FFH. The CRC is CRC-16 (x^16+x^15+x^2+1), computed LSB first from a zero start and sent inverted, low byte first.
- R4: A status read returns status bytes up to an address whose low 3 bits are 111, then a CRC. The first CRC includes the command and the address. Each later CRC is cleared first and covers only that 8-byte page.
- R5: A status read whose page ends at or beyond status address 1FFH sends FFH after that page's CRC.
- R6: A status read returns FFH at status addresses 60H–FFH and at 200H and above, whatever the memory port supplies.
- R7: An extended read first returns the redirection byte of the starting page, read from status address 100H plus the page number. Then it sends a CRC over the command, the address bytes and that redirection byte.
- R8: An extended read then returns data up to the end of the 32-byte page, followed by a CRC over only those data bytes.
- R9: For each later page, an extended read sends the redirection byte and a CRC over that byte alone, then all 32 bytes of the page and their CRC. After the CRC of page 255 it sends FFH.
- R10: A link reset in any state returns the block to idle in the next cycle.
- R11: Without tx_req, tx_byte and the read address hold their values. A tx_req in idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| link_rst | input | 1 | Link-layer reset, returns the block to idle |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Link has taken tx_byte; advance to the next byte |
| tx_byte | output | 8 | Byte to transmit next |
| mem_addr | output | 13 | Memory read address |
| mem_is_status | output | 1 | 1 selects the status field, 0 the data field |
| mem_rdata | input | 8 | Byte read at mem_addr (combinational) |

## Verification
Two events can coincide in the extended read. The data CRC of one page and the fetch of the next page's redirection byte fall on the same CRC-clear and address-increment edge. The same edge must also reach the last-page decision. The bench reads across the boundary from page 1 into page 2, and from page 255 into the end of the field. It compares every byte against a model that clears the CRC on its own at each boundary. The bench also starts a status read just below the unimplemented gap, so that the page CRC and the forced FFH bytes follow each other directly.

// File: rtl/paged_read_seq.sv
module paged_read_seq #(
  parameter int PAGES           = 256,
  parameter int PAGE_BYTES      = 32,
  parameter int STAT_PAGE_BYTES = 8,
  parameter int REDIR_BASE      = 256,
  parameter int STAT_LAST       = 511,
  parameter int STAT_GAP_LO     = 96,
  parameter int STAT_GAP_HI     = 255,
  localparam int AW             = $clog2(PAGES * PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          tx_req,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] mem_addr,
  output logic          mem_is_status,
  input  logic [7:0]    mem_rdata
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int SW = $clog2(STAT_PAGE_BYTES);
  localparam logic [AW-1:0] LAST = AW'(PAGES * PAGE_BYTES - 1);
  localparam logic [7:0] C_RD = 8'hF0, C_ST = 8'hAA, C_EX = 8'hA5;

  typedef enum logic [2:0] {S_IDLE, S_ADRL, S_ADRH, S_DATA, S_RDIR, S_CRC0, S_CRC1, S_ONES} st_t;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  st_t          st;
  logic [7:0]   cmd;
  logic [AW-1:0] addr;
  logic [15:0]  crc;
  logic         rdir_done;

  wire [AW-OW-1:0] page = addr[AW-1:OW];
  wire stat_gap = (addr >= AW'(STAT_GAP_LO) && addr <= AW'(STAT_GAP_HI)) || addr > AW'(STAT_LAST);
  wire [7:0] rd_byte = (cmd == C_ST && stat_gap) ? 8'hFF : mem_rdata;
  wire seg_end = (cmd == C_RD) ? (addr == LAST) :
                 (cmd == C_ST) ? (&addr[SW-1:0]) : (&addr[OW-1:0]);
  wire is_cmd = rx_byte == C_RD || rx_byte == C_ST || rx_byte == C_EX;

  assign mem_is_status = (st == S_RDIR) || (cmd == C_ST);
  assign mem_addr      = (st == S_RDIR) ? AW'(REDIR_BASE) + AW'(page) : addr;

  always_comb begin
    case (st)
      S_DATA:  tx_byte = rd_byte;
      S_RDIR:  tx_byte = mem_rdata;
      S_CRC0:  tx_byte = ~crc[7:0];
      S_CRC1:  tx_byte = ~crc[15:8];
      default: tx_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd <= 8'h00; addr <= '0; crc <= '0; rdir_done <= 1'b0;
    end else if (link_rst) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (rx_valid && is_cmd) begin
          cmd <= rx_byte; crc <= crc_byte(16'h0000, rx_byte); st <= S_ADRL;
        end
        S_ADRL: if (rx_valid) begin
          addr[7:0] <= rx_byte; crc <= crc_byte(crc, rx_byte); st <= S_ADRH;
        end
        S_ADRH: if (rx_valid) begin
          addr[AW-1:8] <= rx_byte[AW-9:0];
          crc <= crc_byte(crc, rx_byte);
          rdir_done <= 1'b0;
          st <= (cmd == C_EX) ? S_RDIR : S_DATA;
        end
        S_DATA: if (tx_req) begin
          crc <= crc_byte(crc, rd_byte);
          if (seg_end) st <= S_CRC0;
          else addr <= addr + 1'b1;
        end
        S_RDIR: if (tx_req) begin
          crc <= crc_byte(crc, mem_rdata); rdir_done <= 1'b1; st <= S_CRC0;
        end
        S_CRC0: if (tx_req) st <= S_CRC1;
        S_CRC1: if (tx_req) begin
          crc <= '0;
          if (cmd == C_RD) st <= S_ONES;
          else if (cmd == C_ST) begin
            if (addr >= AW'(STAT_LAST)) st <= S_ONES;
            else begin addr <= addr + 1'b1; st <= S_DATA; end
          end else if (rdir_done) begin
            rdir_done <= 1'b0; st <= S_DATA;
          end else if (addr == LAST) st <= S_ONES;
          else begin addr <= addr + 1'b1; st <= S_RDIR; end
        end
        default: ;
      endcase
    end
  end

  p_link_rst_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst |=> (st == S_IDLE && tx_byte == 8'hFF));

  p_idle_ignores_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !rx_valid && !link_rst) |=> st == S_IDLE);

  p_hold_without_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && !tx_req && !link_rst) |=> ($stable(addr) && st == S_DATA));

  p_redir_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADRH && rx_valid && cmd == C_EX && !link_rst) |=> st == S_RDIR);

  p_crc_after_redir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDIR && tx_req && !link_rst) |=> st == S_CRC0);

  p_stat_page_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && tx_req && cmd == C_ST && &addr[SW-1:0] && !link_rst) |=> st == S_CRC0);

  p_ones_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ONES && !link_rst) |=> (st == S_ONES && tx_byte == 8'hFF));
endmodule

// File: tb/paged_read_seq_tb.sv
module paged_read_seq_tb;
  logic clk = 0, rst_n = 0, link_rst = 0, rx_valid = 0, tx_req = 0;
  logic [7:0] rx_byte = 0, tx_byte, mem_rdata;
  logic [12:0] mem_addr;
  logic mem_is_status;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  paged_read_seq u_dut (.clk(clk), .rst_n(rst_n), .link_rst(link_rst), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte), .mem_addr(mem_addr),
    .mem_is_status(mem_is_status), .mem_rdata(mem_rdata));

  function automatic logic [7:0] dfun(input logic [12:0] a);
    logic [15:0] t;
    t = {3'b0, a} * 16'd7 + 16'd3;
    return t[7:0] ^ {3'b0, a[12:8]};
  endfunction

  function automatic logic [7:0] sfun(input logic [12:0] a);
    if (a[12:8] == 5'd1) return (a[7:0] == 8'h01) ? 8'hFD : 8'hFF;
    return a[7:0] ^ 8'h3C;
  endfunction

  always_comb mem_rdata = mem_is_status ? sfun(mem_addr) : dfun(mem_addr);

  function automatic logic [15:0] crc16(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic get(input logic [7:0] exp, input string tag);
    @(negedge clk); chk(tx_byte, exp, tag); tx_req = 1;
    @(posedge clk); #1 tx_req = 0;
  endtask

  task automatic get_crc(input logic [15:0] c, input string tag);
    get(~c[7:0], tag);
    get(~c[15:8], tag);
  endtask

  task automatic lreset();
    @(negedge clk); link_rst = 1;
    @(posedge clk); #1 link_rst = 0;
  endtask

  task automatic start(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi,
                       output logic [15:0] crc);
    send(c); send(lo); send(hi);
    crc = crc16(crc16(crc16(16'h0, c), lo), hi);
  endtask

  task automatic t_reset_and_bad_cmd();
    @(negedge clk); chk(tx_byte, 8'hFF, "R10 reset state");
    send(8'h33);
    @(negedge clk); chk(tx_byte, 8'hFF, "R1 bad command ignored");
    send(8'hF0);
    @(negedge clk); chk(tx_byte, 8'hFF, "R1 tx FF during address");
    lreset();
  endtask

  task automatic t_plain_end();
    logic [15:0] c;
    start(8'hF0, 8'hFC, 8'hFF, c);
    for (int a = 13'h1FFC; a <= 13'h1FFF; a++) begin
      get(dfun(13'(a)), "R2 R3 plain data, masked address");
      c = crc16(c, dfun(13'(a)));
    end
    get_crc(c, "R3 plain CRC");
    get(8'hFF, "R3 ones after CRC");
    get(8'hFF, "R3 ones after CRC");
    lreset();
  endtask

  task automatic t_plain_abort_hold();
    logic [15:0] c;
    start(8'hF0, 8'h10, 8'h00, c);
    get(dfun(13'h10), "R3 plain data");
    get(dfun(13'h11), "R3 plain data");
    lreset();
    @(negedge clk); chk(tx_byte, 8'hFF, "R10 link reset mid-read");
    @(negedge clk); tx_req = 1; @(posedge clk); #1 tx_req = 0;
    start(8'hF0, 8'h20, 8'h00, c);
    get(dfun(13'h20), "R11 idle tx_req had no effect");
    repeat (5) @(posedge clk);
    @(negedge clk); chk(tx_byte, dfun(13'h21), "R11 hold without tx_req");
    lreset();
  endtask

  task automatic t_status_pages();
    logic [15:0] c;
    start(8'hAA, 8'h05, 8'h00, c);
    for (int a = 5; a <= 7; a++) begin
      get(sfun(13'(a)), "R4 status data");
      c = crc16(c, sfun(13'(a)));
    end
    get_crc(c, "R4 first status CRC");
    c = 16'h0;
    for (int a = 8; a <= 15; a++) begin
      get(sfun(13'(a)), "R4 status data page 2");
      c = crc16(c, sfun(13'(a)));
    end
    get_crc(c, "R4 cleared status CRC");
    lreset();
  endtask

  task automatic t_status_gap_end();
    logic [15:0] c;
    start(8'hAA, 8'h5E, 8'h00, c);
    for (int a = 16'h5E; a <= 16'h5F; a++) begin
      get(sfun(13'(a)), "R6 status before gap");
      c = crc16(c, sfun(13'(a)));
    end
    get_crc(c, "R4 status CRC before gap");
    c = 16'h0;
    for (int a = 0; a < 8; a++) begin
      get(8'hFF, "R6 unimplemented status reads FF");
      c = crc16(c, 8'hFF);
    end
    get_crc(c, "R6 CRC of FF page");
    lreset();
    start(8'hAA, 8'hFD, 8'h01, c);
    for (int a = 16'h1FD; a <= 16'h1FF; a++) begin
      get(sfun(13'(a)), "R5 last status page");
      c = crc16(c, sfun(13'(a)));
    end
    get_crc(c, "R5 last status CRC");
    get(8'hFF, "R5 ones after last status page");
    lreset();
    start(8'hAA, 8'h06, 8'h03, c);
    get(8'hFF, "R6 status 306H reads FF");
    c = crc16(c, 8'hFF);
    get(8'hFF, "R6 status 307H reads FF");
    c = crc16(c, 8'hFF);
    get_crc(c, "R5 CRC of page above field");
    get(8'hFF, "R5 ones beyond status field");
    lreset();
  endtask

  task automatic t_extended_two_pages();
    logic [15:0] c;
    start(8'hA5, 8'h23, 8'h00, c);
    get(8'hFD, "R7 first redirection byte from 101H");
    c = crc16(c, 8'hFD);
    get_crc(c, "R7 CRC over command, address, redirection");
    c = 16'h0;
    for (int a = 16'h23; a <= 16'h3F; a++) begin
      get(dfun(13'(a)), "R8 extended data");
      c = crc16(c, dfun(13'(a)));
    end
    get_crc(c, "R8 page data CRC");
    get(8'hFF, "R9 next redirection byte from 102H");
    get_crc(crc16(16'h0, 8'hFF), "R9 CRC over redirection byte only");
    c = 16'h0;
    for (int a = 16'h40; a <= 16'h5F; a++) begin
      get(dfun(13'(a)), "R9 next page data");
      c = crc16(c, dfun(13'(a)));
    end
    get_crc(c, "R9 next page CRC");
    lreset();
  endtask

  task automatic t_extended_last();
    logic [15:0] c;
    start(8'hA5, 8'hFE, 8'h1F, c);
    get(8'hFF, "R7 redirection byte page 255");
    c = crc16(c, 8'hFF);
    get_crc(c, "R7 first CRC last page");
    c = 16'h0;
    for (int a = 16'h1FFE; a <= 16'h1FFF; a++) begin
      get(dfun(13'(a)), "R8 last page data");
      c = crc16(c, dfun(13'(a)));
    end
    get_crc(c, "R8 last page CRC");
    get(8'hFF, "R9 ones after last page");
    get(8'hFF, "R9 ones after last page");
    lreset();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset_and_bad_cmd();
    t_plain_end();
    t_plain_abort_hold();
    t_status_pages();
    t_status_gap_end();
    t_extended_two_pages();
    t_extended_last();
    repeat (2) @(posedge clk);
    summary();
  end
endmodule